// File: doc/BRIEF.md
# Dual-Source Change-of-Flow Trace Packer

This block turns program-flow and bus-access events from two independent processors, a main CPU with a 24-bit program counter and a coprocessor with a 16-bit program counter, into 64-bit lines for a trace RAM. In flow mode, each change of flow produces a record of the processor's info byte and program counter. When both processors are traced, one line holds both program counters. The processor that changed flow is marked valid. The other processor's program counter is stored as a plain snapshot. When only one processor is traced, two records share a line.

In detail mode, each bus access of the selected processor produces one line. The line holds a combined access-info byte, both processors' access addresses, and two data bytes that are steered according to access size and byte lane. The block drives a one-line write port and a counter that tracks the fill level. The counter's lowest bit counts half-lines. Writes are registered. Each line appears on the write port one clock after the cycle of the event that completes it.

Top module: `cof_trace_packer`

## Requirements
- R1: With `src_sel`=2'b11 (both) and `mode_detail`=0, a cycle with `m_cof` or `c_cof` high writes one line. From byte 7 down to byte 0 the line holds: 8'h00, the coprocessor info byte {`c_cof`, `c_info`}, `c_pc` (2 bytes), the main info byte {`m_cof`, `m_info`}, `m_pc` (3 bytes).
- R2: In such a both-source line, the info-byte bit 7 of the processor that did not change flow is 0. Its program counter is still recorded as the value present in that cycle.
- R3: When `m_cof` and `c_cof` are high in the same cycle in both-source flow mode, exactly one line is written, and both info-byte valid bits are 1.
- R4: With `src_sel`=2'b01 (main only) in flow mode, each `m_cof` forms a 32-bit record {1'b1, `m_info`, `m_pc`}. The first record of a pair goes to bits 31:0, the second goes to bits 63:32, and the line is written when the second record arrives.
- R5: With `src_sel`=2'b10 (coprocessor only) in flow mode, each `c_cof` forms a 24-bit record {1'b1, `c_info`, `c_pc`}. The record sits in bits 23:0 (first) or 55:32 (second). Bits 31:24 and 63:56 are zero, and `m_cof` is ignored.
- R6: `entry_cnt` rises by 1 for each single-source flow record. For each both-source line or detail line, its upper bits rise by 1 and bit 0 reads 0.
- R7: In detail mode, an access with the selected processor's valid input high writes one line, from byte 7 to 0, as follows.
  - Byte 7 is the info byte {`m_acc_vld`, `m_acc_wr`, `m_acc_word`, 0, `c_acc_vld`, `c_acc_wr`, `c_acc_word`, 0}.
  - Bytes 6 to 4 hold `m_acc_addr`, bytes 3 and 2 hold data, and bytes 1 and 0 hold `c_acc_addr`.
  - The selected processor is the coprocessor when `src_sel`=2'b10 and the main CPU otherwise.
- R8: A detail byte access writes byte 3 as zero and places the accessed byte in byte 2. The accessed byte is taken from data bits 15:8 for an even address and bits 7:0 for an odd address.
- R9: A detail word access stores data bits 15:8 (the byte at the lower address) in line byte 3 and data bits 7:0 (the higher address) in byte 2.
- R10: `wr_addr` starts at 0 after reset, advances by one per written line, and wraps from LINES-1 to 0.
- R11: On a 1-to-0 transition of `arm` with a single-source half-line pending, the half-line is written with bits 63:32 zero. While `arm` is 0, no event produces a record.
- R12: A synchronous active-high `rst` clears `entry_cnt`, `wr_addr`, `wr_en` and any pending half-line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Tracing enabled; falling edge flushes a pending half-line |
| mode_detail | input | 1 | 1 = detail (bus access) format, 0 = flow format |
| src_sel | input | 2 | 01 main only, 10 coprocessor only, 11 both, 00 none |
| m_cof | input | 1 | Main CPU change-of-flow strobe |
| m_pc | input | 24 | Main CPU program counter |
| m_info | input | 7 | Main CPU info bits |
| c_cof | input | 1 | Coprocessor change-of-flow strobe |
| c_pc | input | 16 | Coprocessor program counter |
| c_info | input | 7 | Coprocessor info bits |
| m_acc_vld | input | 1 | Main CPU bus access valid |
| m_acc_wr | input | 1 | Main CPU access is a write |
| m_acc_word | input | 1 | Main CPU access is 16-bit |
| m_acc_addr | input | 24 | Main CPU access address |
| m_acc_data | input | 16 | Main CPU access data, big-endian lanes |
| c_acc_vld | input | 1 | Coprocessor bus access valid |
| c_acc_wr | input | 1 | Coprocessor access is a write |
| c_acc_word | input | 1 | Coprocessor access is 16-bit |
| c_acc_addr | input | 16 | Coprocessor access address |
| c_acc_data | input | 16 | Coprocessor access data, big-endian lanes |
| wr_en | output | 1 | Trace RAM line write strobe |
| wr_addr | output | PTR_W (6) | Trace RAM line index |
| wr_data | output | 64 | Trace RAM line data |
| entry_cnt | output | PTR_W+1 (7) | Entry counter, bit 0 counts half-lines |

## Verification
Every result is registered once. An event presented in cycle N shows up on `wr_en`, `wr_addr`, `wr_data` and `entry_cnt` just after clock edge N. A pending single-source record changes only `entry_cnt` at that edge, and its line appears one edge after the second record or the disarm cycle. The bench drives a new input set shortly after each rising edge and compares all outputs shortly after the following rising edge. Each expectation is therefore tied to exactly one register stage, and no check can race the edge.

// File: rtl/cft_pkg.sv
package cft_pkg;
    localparam int MPC_W  = 24;
    localparam int CPC_W  = 16;
    localparam int INFO_W = 7;
    localparam int DATA_W = 16;
    localparam int HALF_W = 32;
    localparam int LINE_W = 64;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_MAIN = 2'b01,
        SRC_COP  = 2'b10,
        SRC_BOTH = 2'b11
    } src_sel_e;
endpackage

// File: rtl/cft_flow_fmt.sv
module cft_flow_fmt
    import cft_pkg::*;
(
    input  logic              m_cof,
    input  logic              c_cof,
    input  logic [MPC_W-1:0]  m_pc,
    input  logic [INFO_W-1:0] m_info,
    input  logic [CPC_W-1:0]  c_pc,
    input  logic [INFO_W-1:0] c_info,
    output logic [LINE_W-1:0] both_line,
    output logic [HALF_W-1:0] main_half,
    output logic [HALF_W-1:0] cop_half
);
    localparam int COP_PAD = HALF_W - 1 - INFO_W - CPC_W;

    always_comb begin
        // Valid bit in bit 7 marks the processor whose flow changed.
        both_line = {8'h00, c_cof, c_info, c_pc, m_cof, m_info, m_pc};
        main_half = {1'b1, m_info, m_pc};
        cop_half  = {{COP_PAD{1'b0}}, 1'b1, c_info, c_pc};
    end
endmodule

// File: rtl/cft_data_steer.sv
module cft_data_steer
    import cft_pkg::*;
(
    input  logic              word,
    input  logic              addr_lsb,
    input  logic [DATA_W-1:0] data,
    output logic [7:0]        byte_hi,
    output logic [7:0]        byte_lo
);
    always_comb begin
        if (word) begin
            byte_hi = data[15:8];
            byte_lo = data[7:0];
        end else begin
            byte_hi = 8'h00;
            byte_lo = addr_lsb ? data[7:0] : data[15:8];
        end
    end
endmodule

// File: rtl/cft_detail_fmt.sv
module cft_detail_fmt
    import cft_pkg::*;
(
    input  logic              use_cop,
    input  logic              m_vld,
    input  logic              m_wr,
    input  logic              m_word,
    input  logic [MPC_W-1:0]  m_addr,
    input  logic [DATA_W-1:0] m_data,
    input  logic              c_vld,
    input  logic              c_wr,
    input  logic              c_word,
    input  logic [CPC_W-1:0]  c_addr,
    input  logic [DATA_W-1:0] c_data,
    output logic              sel_word,
    output logic [LINE_W-1:0] line
);
    logic              sel_lsb;
    logic [DATA_W-1:0] sel_data;
    logic [7:0]        hi_b;
    logic [7:0]        lo_b;
    logic [7:0]        info_b;

    always_comb begin
        sel_word = use_cop ? c_word    : m_word;
        sel_lsb  = use_cop ? c_addr[0] : m_addr[0];
        sel_data = use_cop ? c_data    : m_data;
    end

    cft_data_steer steer_i (
        .word     (sel_word),
        .addr_lsb (sel_lsb),
        .data     (sel_data),
        .byte_hi  (hi_b),
        .byte_lo  (lo_b)
    );

    always_comb begin
        info_b = {m_vld, m_wr, m_word, 1'b0, c_vld, c_wr, c_word, 1'b0};
        line   = {info_b, m_addr, hi_b, lo_b, c_addr};
    end
endmodule

// File: rtl/cof_trace_packer.sv
module cof_trace_packer
    import cft_pkg::*;
#(
    parameter  int LINES = 64,
    localparam int PTR_W = $clog2(LINES),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              mode_detail,
    input  logic [1:0]        src_sel,
    input  logic              m_cof,
    input  logic [MPC_W-1:0]  m_pc,
    input  logic [INFO_W-1:0] m_info,
    input  logic              c_cof,
    input  logic [CPC_W-1:0]  c_pc,
    input  logic [INFO_W-1:0] c_info,
    input  logic              m_acc_vld,
    input  logic              m_acc_wr,
    input  logic              m_acc_word,
    input  logic [MPC_W-1:0]  m_acc_addr,
    input  logic [DATA_W-1:0] m_acc_data,
    input  logic              c_acc_vld,
    input  logic              c_acc_wr,
    input  logic              c_acc_word,
    input  logic [CPC_W-1:0]  c_acc_addr,
    input  logic [DATA_W-1:0] c_acc_data,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [LINE_W-1:0] wr_data,
    output logic              [CNT_W-1:0] entry_cnt
);
    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [CNT_W-1:0]  cnt;
        logic              pend;
        logic [HALF_W-1:0] half;
        logic              arm;
        logic              we;
        logic [PTR_W-1:0]  waddr;
        logic [LINE_W-1:0] wdata;
    } state_t;

    state_t st_d, st_q;

    src_sel_e          src;
    logic              use_cop;
    logic              sel_word;
    logic [LINE_W-1:0] both_line;
    logic [LINE_W-1:0] det_line;
    logic [HALF_W-1:0] main_half;
    logic [HALF_W-1:0] cop_half;
    logic [HALF_W-1:0] new_half;
    logic              flush_fire;
    logic              both_fire;
    logic              single_fire;
    logic              det_fire;
    logic [CNT_W-2:0]  cnt_hi_inc;

    assign src     = src_sel_e'(src_sel);
    assign use_cop = (src == SRC_COP);

    cft_flow_fmt flow_i (
        .m_cof     (m_cof),
        .c_cof     (c_cof),
        .m_pc      (m_pc),
        .m_info    (m_info),
        .c_pc      (c_pc),
        .c_info    (c_info),
        .both_line (both_line),
        .main_half (main_half),
        .cop_half  (cop_half)
    );

    cft_detail_fmt detail_i (
        .use_cop  (use_cop),
        .m_vld    (m_acc_vld),
        .m_wr     (m_acc_wr),
        .m_word   (m_acc_word),
        .m_addr   (m_acc_addr),
        .m_data   (m_acc_data),
        .c_vld    (c_acc_vld),
        .c_wr     (c_acc_wr),
        .c_word   (c_acc_word),
        .c_addr   (c_acc_addr),
        .c_data   (c_acc_data),
        .sel_word (sel_word),
        .line     (det_line)
    );

    always_comb begin
        flush_fire  = st_q.arm && !arm && st_q.pend;
        both_fire   = arm && !mode_detail && (src == SRC_BOTH) && (m_cof || c_cof);
        single_fire = arm && !mode_detail &&
                      (((src == SRC_MAIN) && m_cof) || ((src == SRC_COP) && c_cof));
        det_fire    = arm && mode_detail && (src != SRC_NONE) &&
                      (use_cop ? c_acc_vld : m_acc_vld);
        new_half    = use_cop ? cop_half : main_half;
        cnt_hi_inc  = st_q.cnt[CNT_W-1:1] + 1'b1;

        st_d     = st_q;
        st_d.we  = 1'b0;
        st_d.arm = arm;

        if (flush_fire) begin
            st_d.we    = 1'b1;
            st_d.waddr = st_q.ptr;
            st_d.wdata = {{HALF_W{1'b0}}, st_q.half};
            st_d.ptr   = st_q.ptr + 1'b1;
            st_d.pend  = 1'b0;
            st_d.half  = '0;
        end else if (both_fire) begin
            st_d.we    = 1'b1;
            st_d.waddr = st_q.ptr;
            st_d.wdata = both_line;
            st_d.ptr   = st_q.ptr + 1'b1;
            st_d.cnt   = {cnt_hi_inc, 1'b0};
        end else if (single_fire) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.pend) begin
                st_d.we    = 1'b1;
                st_d.waddr = st_q.ptr;
                st_d.wdata = {new_half, st_q.half};
                st_d.ptr   = st_q.ptr + 1'b1;
                st_d.pend  = 1'b0;
                st_d.half  = '0;
            end else begin
                st_d.pend = 1'b1;
                st_d.half = new_half;
            end
        end else if (det_fire) begin
            st_d.we    = 1'b1;
            st_d.waddr = st_q.ptr;
            st_d.wdata = det_line;
            st_d.ptr   = st_q.ptr + 1'b1;
            st_d.cnt   = {cnt_hi_inc, 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en     = st_q.we;
    assign wr_addr   = st_q.waddr;
    assign wr_data   = st_q.wdata;
    assign entry_cnt = st_q.cnt;

    // R1: both-source lines carry a zero top byte
    p_both_top_zero_r1: assert property (@(posedge clk) disable iff (rst)
        both_fire |=> (wr_en && wr_data[63:56] == 8'h00));

    // R4: a second single-source record completes a line
    p_pair_writes_r4: assert property (@(posedge clk) disable iff (rst)
        (single_fire && st_q.pend) |=> wr_en);

    // R6: detail entries leave counter bit 0 clear
    p_det_cnt_even_r6: assert property (@(posedge clk) disable iff (rst)
        det_fire |=> !entry_cnt[0]);

    // R8: byte accesses clear the high data byte
    p_byte_hi_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (det_fire && !sel_word) |=> (wr_data[31:24] == 8'h00));

    // R10: each written line advances the pointer by one
    p_ptr_step_r10: assert property (@(posedge clk) disable iff (rst)
        st_d.we |=> (st_q.ptr == PTR_W'($past(st_q.ptr) + 1'b1)));

    // R11: nothing is written while disarmed after the flush cycle
    p_idle_off_r11: assert property (@(posedge clk) disable iff (rst)
        (!arm && !st_q.arm) |=> !wr_en);

    // R12: reset clears the counter and the write strobe
    p_rst_clear_r12: assert property (@(posedge clk)
        rst |=> (entry_cnt == '0 && !wr_en && wr_addr == '0));
endmodule

// File: tb/cof_trace_packer_tb_top.sv
module cof_trace_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        arm;
    logic        mode_detail;
    logic [1:0]  src_sel;
    logic        m_cof;
    logic [23:0] m_pc;
    logic [6:0]  m_info;
    logic        c_cof;
    logic [15:0] c_pc;
    logic [6:0]  c_info;
    logic        m_acc_vld, m_acc_wr, m_acc_word;
    logic [23:0] m_acc_addr;
    logic [15:0] m_acc_data;
    logic        c_acc_vld, c_acc_wr, c_acc_word;
    logic [15:0] c_acc_addr;
    logic [15:0] c_acc_data;
    logic        wr_en;
    logic [5:0]  wr_addr;
    logic [63:0] wr_data;
    logic [6:0]  entry_cnt;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cof_trace_packer dut_i (
        .clk(clk), .rst(rst), .arm(arm), .mode_detail(mode_detail), .src_sel(src_sel),
        .m_cof(m_cof), .m_pc(m_pc), .m_info(m_info),
        .c_cof(c_cof), .c_pc(c_pc), .c_info(c_info),
        .m_acc_vld(m_acc_vld), .m_acc_wr(m_acc_wr), .m_acc_word(m_acc_word),
        .m_acc_addr(m_acc_addr), .m_acc_data(m_acc_data),
        .c_acc_vld(c_acc_vld), .c_acc_wr(c_acc_wr), .c_acc_word(c_acc_word),
        .c_acc_addr(c_acc_addr), .c_acc_data(c_acc_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .entry_cnt(entry_cnt)
    );

    typedef struct packed {
        logic        arm;
        logic [1:0]  src;
        logic        mc;
        logic        cc;
        logic [6:0]  mi;
        logic [23:0] mpc;
        logic [6:0]  ci;
        logic [15:0] cpc;
        logic        we;
        logic [5:0]  addr;
        logic [63:0] data;
        logic [6:0]  cnt;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        // R1 R2: main changes flow, coprocessor snapshot
        '{1'b1, 2'b11, 1'b1, 1'b0, 7'h11, 24'h123456, 7'h22, 16'hABCD, 1'b1, 6'd0, 64'h0022ABCD_91123456, 7'd2},
        // R1 R2: coprocessor changes flow, main snapshot
        '{1'b1, 2'b11, 1'b0, 1'b1, 7'h05, 24'h0A0B0C, 7'h7F, 16'h1234, 1'b1, 6'd1, 64'h00FF1234_050A0B0C, 7'd4},
        // R3: simultaneous
        '{1'b1, 2'b11, 1'b1, 1'b1, 7'h01, 24'h000001, 7'h02, 16'h0002, 1'b1, 6'd2, 64'h00820002_81000001, 7'd6},
        // R1: no event, no write
        '{1'b1, 2'b11, 1'b0, 1'b0, 7'h01, 24'h000001, 7'h02, 16'h0002, 1'b0, 6'd0, 64'h0, 7'd6},
        // R4 R6: main-only first record pending
        '{1'b1, 2'b01, 1'b1, 1'b0, 7'h33, 24'hAABBCC, 7'h00, 16'h0000, 1'b0, 6'd0, 64'h0, 7'd7},
        // R4: second record completes line
        '{1'b1, 2'b01, 1'b1, 1'b0, 7'h44, 24'hDDEEFF, 7'h00, 16'h0000, 1'b1, 6'd3, 64'hC4DDEEFF_B3AABBCC, 7'd8},
        // R5: coprocessor-only first record
        '{1'b1, 2'b10, 1'b0, 1'b1, 7'h00, 24'h000000, 7'h10, 16'h5555, 1'b0, 6'd0, 64'h0, 7'd9},
        // R5: second record, m_cof ignored
        '{1'b1, 2'b10, 1'b1, 1'b1, 7'h7F, 24'hFFFFFF, 7'h20, 16'h6666, 1'b1, 6'd4, 64'h00A06666_00905555, 7'd10},
        // R11: pending half before disarm
        '{1'b1, 2'b01, 1'b1, 1'b0, 7'h01, 24'h111111, 7'h00, 16'h0000, 1'b0, 6'd0, 64'h0, 7'd11},
        // R11: disarm flushes half-line
        '{1'b0, 2'b01, 1'b0, 1'b0, 7'h00, 24'h000000, 7'h00, 16'h0000, 1'b1, 6'd5, 64'h00000000_81111111, 7'd11},
        // R11: events ignored while disarmed
        '{1'b0, 2'b01, 1'b1, 1'b0, 7'h09, 24'h999999, 7'h00, 16'h0000, 1'b0, 6'd0, 64'h0, 7'd11}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        arm = 1'b0; mode_detail = 1'b0; src_sel = 2'b00;
        m_cof = 1'b0; m_pc = '0; m_info = '0;
        c_cof = 1'b0; c_pc = '0; c_info = '0;
        m_acc_vld = 1'b0; m_acc_wr = 1'b0; m_acc_word = 1'b0; m_acc_addr = '0; m_acc_data = '0;
        c_acc_vld = 1'b0; c_acc_wr = 1'b0; c_acc_word = 1'b0; c_acc_addr = '0; c_acc_data = '0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic chk_line(input string req, input logic [5:0] a, input logic [63:0] d, input logic [6:0] c);
        chk(wr_en == 1'b1, req, {63'h0, wr_en}, 64'h1);
        chk(wr_addr == a, req, {58'h0, wr_addr}, {58'h0, a});
        chk(wr_data == d, req, wr_data, d);
        chk(entry_cnt == c, req, {57'h0, entry_cnt}, {57'h0, c});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R12: reset state
        chk(wr_en == 1'b0, "R12", {63'h0, wr_en}, 64'h0);
        chk(entry_cnt == 7'd0, "R12", {57'h0, entry_cnt}, 64'h0);
        chk(wr_addr == 6'd0, "R12", {58'h0, wr_addr}, 64'h0);

        // Flow-mode vector table
        for (int i = 0; i < NV; i++) begin
            arm = VEC[i].arm; src_sel = VEC[i].src; mode_detail = 1'b0;
            m_cof = VEC[i].mc; c_cof = VEC[i].cc;
            m_info = VEC[i].mi; m_pc = VEC[i].mpc;
            c_info = VEC[i].ci; c_pc = VEC[i].cpc;
            step();
            chk(wr_en == VEC[i].we, $sformatf("R1-table row %0d we", i), {63'h0, wr_en}, {63'h0, VEC[i].we});
            if (VEC[i].we) begin
                chk(wr_addr == VEC[i].addr, $sformatf("R10 row %0d", i), {58'h0, wr_addr}, {58'h0, VEC[i].addr});
                chk(wr_data == VEC[i].data, $sformatf("R4 R5 row %0d data", i), wr_data, VEC[i].data);
            end
            chk(entry_cnt == VEC[i].cnt, $sformatf("R6 row %0d cnt", i), {57'h0, entry_cnt}, {57'h0, VEC[i].cnt});
        end

        // Detail mode tests
        do_reset();
        arm = 1'b1; mode_detail = 1'b1; src_sel = 2'b01;
        // R9: word access, main selected
        m_acc_vld = 1'b1; m_acc_wr = 1'b1; m_acc_word = 1'b1;
        m_acc_addr = 24'h345678; m_acc_data = 16'hBEEF; c_acc_addr = 16'h9ABC;
        step();
        chk_line("R9 R7", 6'd0, 64'hE0345678_BEEF9ABC, 7'd2);
        // R8: byte access at odd address
        m_acc_wr = 1'b0; m_acc_word = 1'b0; m_acc_addr = 24'h000011;
        m_acc_data = 16'h1234; c_acc_addr = 16'h0000;
        step();
        chk_line("R8 odd", 6'd1, 64'h80000011_00340000, 7'd4);
        // R8: byte access at even address
        m_acc_addr = 24'h000010; m_acc_data = 16'h5678;
        step();
        chk_line("R8 even", 6'd2, 64'h80000010_00560000, 7'd6);
        // R7: coprocessor selected
        src_sel = 2'b10; m_acc_vld = 1'b0; m_acc_addr = '0; m_acc_data = 16'hFFFF;
        c_acc_vld = 1'b1; c_acc_wr = 1'b0; c_acc_word = 1'b1;
        c_acc_addr = 16'h4000; c_acc_data = 16'hCAFE;
        step();
        chk_line("R7 cop", 6'd3, 64'h0A000000_CAFE4000, 7'd8);
        // R7: selected processor idle, no entry
        src_sel = 2'b01; c_acc_vld = 1'b1;
        step();
        chk(wr_en == 1'b0, "R7 idle", {63'h0, wr_en}, 64'h0);
        chk(entry_cnt == 7'd8, "R6 idle", {57'h0, entry_cnt}, 64'd8);

        // R10: pointer wrap
        do_reset();
        arm = 1'b1; src_sel = 2'b11; m_cof = 1'b1; m_pc = 24'h00C0DE;
        for (int k = 0; k < 64; k++) begin
            step();
        end
        chk(wr_addr == 6'd63, "R10 last", {58'h0, wr_addr}, 64'd63);
        chk(entry_cnt == 7'd0, "R6 wrap", {57'h0, entry_cnt}, 64'd0);
        step();
        chk(wr_addr == 6'd0, "R10 wrap", {58'h0, wr_addr}, 64'd0);
        chk(entry_cnt == 7'd2, "R6 after wrap", {57'h0, entry_cnt}, 64'd2);

        // R12: reset discards a pending half-line
        do_reset();
        arm = 1'b1; src_sel = 2'b01; m_cof = 1'b1; m_pc = 24'h777777;
        step();
        chk(entry_cnt == 7'd1, "R12 pend", {57'h0, entry_cnt}, 64'd1);
        rst = 1'b1; m_cof = 1'b0;
        step();
        rst = 1'b0;
        step();
        arm = 1'b0;
        step();
        chk(wr_en == 1'b0, "R12 no flush", {63'h0, wr_en}, 64'h0);
        chk(entry_cnt == 7'd0, "R12 cnt", {57'h0, entry_cnt}, 64'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule